// File: doc/BRIEF.md
# Block Address Translation Matcher

This block keeps two small tables of large-region address mappings, one for instruction fetches and one for data accesses, each holding eight entries. A lookup presents a 32-bit effective address, whether the access is a fetch or a data access, and whether the processor runs in user or supervisor mode. The block searches the chosen table in a single combinational pass and registers the result one cycle later. The result is a hit flag, the translated physical address, the read/write/execute permissions and a virtual page tag marked as coming from a block mapping.

Each entry holds a compare pattern, a compare mask, a physical base, a valid bit for each privilege level and a two-bit protection code. Software loads one whole entry per cycle through a simple write port. A miss is only reported. Any fallback walk or fault handling belongs to the surrounding logic.

Top module: `blkmap_xlate`

## Requirements
- R1: After reset every entry of both tables is invalid, so every lookup misses. A missed lookup returns hit, read, write and execute all 0, a physical address of 0 and a tag of 0.
- R2: With reqData=0 the lookup searches only the instruction table (wrSide=0). With reqData=1 it searches only the data table (wrSide=1).
- R3: An entry takes part in a lookup only if its user-valid bit is set when reqUser=1, or its supervisor-valid bit is set when reqUser=0.
- R4: An entry's address compare succeeds when (reqAddr AND mask) equals its pattern. A mask bit of 1 marks an address bit that is compared.
- R5: On a hit, the physical address is the entry's base ORed with (reqAddr AND NOT mask).
- R6: An entry whose protection code is 0 or 1 is skipped, and the search goes on to later entries. A hit through an entry with code 2 or 3 reports read=1, write=1 and execute=1.
- R7: When several entries qualify, the one with the lowest index wins.
- R8: On a hit, the 21-bit tag is {1'b1, reqAddr[31:12]}. Bit 20 is the block-mapping marker.
- R9: rspValid is high exactly one cycle after reqValid. The result outputs change only on that cycle and otherwise hold. A lookup in the same cycle as a write to the entry it uses still sees that entry's old contents.
- R10: wrEn=1 loads pattern, mask, base, both valid bits and the protection code into entry wrIdx of the table picked by wrSide. No other entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Entry write strobe |
| wrSide | input | 1 | Table to write: 0 instruction, 1 data |
| wrIdx | input | 3 | Entry index to write |
| wrPattern | input | 32 | Compare pattern |
| wrMask | input | 32 | Compare mask (1 = compared) |
| wrBase | input | 32 | Physical base |
| wrSupV | input | 1 | Valid in supervisor mode |
| wrUserV | input | 1 | Valid in user mode |
| wrProt | input | 2 | Protection code |
| reqValid | input | 1 | Lookup request |
| reqAddr | input | 32 | Effective address |
| reqData | input | 1 | 1 = data access, 0 = instruction fetch |
| reqUser | input | 1 | 1 = user mode, 0 = supervisor mode |
| rspValid | output | 1 | Result valid, one cycle after reqValid |
| rspHit | output | 1 | A qualifying entry was found |
| rspPhys | output | 32 | Physical address |
| rspRead | output | 1 | Read permitted |
| rspWrite | output | 1 | Write permitted |
| rspExec | output | 1 | Execute permitted |
| rspTag | output | 21 | Virtual page tag with block marker |

## Verification
The hardest case to reach from the ports is a lookup where a lower-index entry matches the address but is disqualified, either by its protection code or by the privilege level, so that a later overlapping entry must win. Random entries and addresses would almost never line up this way. The stimulus therefore writes deliberately overlapping entries into one table, with differing protection codes and valid bits, and probes the shared region in both privilege levels. Random traffic then draws masks from the aligned power-of-two sizes and builds most addresses from an existing entry's pattern, so that overlaps and priority contests occur often.

// File: rtl/blkmap_pkg.sv
package blkmap_pkg;
  parameter int unsigned ENTRY_NUM = 8;
  parameter int unsigned ADDR_W    = 32;
  parameter int unsigned PAGE_LSB  = 12;
  localparam int unsigned IDX_W    = $clog2(ENTRY_NUM);
  localparam int unsigned PROT_W   = 2;
  localparam int unsigned TAG_W    = ADDR_W - PAGE_LSB + 1;

  typedef struct packed {
    logic [ADDR_W-1:0] pattern;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] base;
    logic              supV;
    logic              userV;
    logic [PROT_W-1:0] prot;
  } entry_t;

  typedef struct packed {
    logic [ENTRY_NUM-1:0] wrSelInst;
    logic [ENTRY_NUM-1:0] wrSelData;
    logic                 capture;
  } strobe_t;
endpackage

// File: rtl/blkmap_ctrl.sv
module blkmap_ctrl
  import blkmap_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSide,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             reqValid,
  output strobe_t          strobe,
  output logic             rspValid
);
  for (genvar g = 0; g < ENTRY_NUM; g++) begin : g_sel
    assign strobe.wrSelInst[g] = wrEn && !wrSide && (wrIdx == IDX_W'(g));
    assign strobe.wrSelData[g] = wrEn &&  wrSide && (wrIdx == IDX_W'(g));
  end
  assign strobe.capture = reqValid;

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end

  // R10
  one_entry_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrSelInst, strobe.wrSelData}));
endmodule

// File: rtl/blkmap_dp.sv
module blkmap_dp
  import blkmap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] wrPattern,
  input  logic [ADDR_W-1:0] wrMask,
  input  logic [ADDR_W-1:0] wrBase,
  input  logic              wrSupV,
  input  logic              wrUserV,
  input  logic [PROT_W-1:0] wrProt,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqData,
  input  logic              reqUser,
  output logic              rspHit,
  output logic [ADDR_W-1:0] rspPhys,
  output logic              rspRead,
  output logic              rspWrite,
  output logic              rspExec,
  output logic [TAG_W-1:0]  rspTag
);
  entry_t instTab [ENTRY_NUM];
  entry_t dataTab [ENTRY_NUM];
  entry_t candE   [ENTRY_NUM];
  entry_t newEntry;
  entry_t selEntry;
  logic [ENTRY_NUM-1:0] qualVec;
  logic [IDX_W-1:0]     hitIdx;
  logic                 hitAny;

  assign newEntry = '{pattern: wrPattern, mask: wrMask, base: wrBase,
                      supV: wrSupV, userV: wrUserV, prot: wrProt};

  for (genvar g = 0; g < ENTRY_NUM; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        instTab[g] <= '0;
        dataTab[g] <= '0;
      end else begin
        if (strobe.wrSelInst[g]) instTab[g] <= newEntry;
        if (strobe.wrSelData[g]) dataTab[g] <= newEntry;
      end
    end

    assign candE[g] = reqData ? dataTab[g] : instTab[g];

    logic modeOk, addrOk, protOk;
    assign modeOk = reqUser ? candE[g].userV : candE[g].supV;
    assign addrOk = (reqAddr & candE[g].mask) == candE[g].pattern;
    assign protOk = candE[g].prot[PROT_W-1];
    assign qualVec[g] = modeOk && addrOk && protOk;
  end

  always_comb begin
    hitAny = 1'b0;
    hitIdx = '0;
    for (int i = ENTRY_NUM - 1; i >= 0; i--) begin
      if (qualVec[i]) begin
        hitAny = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  assign selEntry = candE[hitIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspHit   <= 1'b0;
      rspPhys  <= '0;
      rspRead  <= 1'b0;
      rspWrite <= 1'b0;
      rspExec  <= 1'b0;
      rspTag   <= '0;
    end else if (strobe.capture) begin
      rspHit   <= hitAny;
      rspRead  <= hitAny;
      rspWrite <= hitAny && (selEntry.prot > PROT_W'(1));
      rspExec  <= hitAny;
      if (hitAny) begin
        rspPhys <= selEntry.base | (reqAddr & ~selEntry.mask);
        rspTag  <= {1'b1, reqAddr[ADDR_W-1:PAGE_LSB]};
      end else begin
        rspPhys <= '0;
        rspTag  <= '0;
      end
    end
  end

  // R6
  hit_perms_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> (rspRead && rspWrite && rspExec));
  // R8
  hit_marker_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> rspTag[TAG_W-1]);
  // R1
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspHit |-> (rspPhys == '0 && rspTag == '0 && !rspRead && !rspWrite && !rspExec));
endmodule

// File: rtl/blkmap_xlate.sv
module blkmap_xlate
  import blkmap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSide,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ADDR_W-1:0] wrPattern,
  input  logic [ADDR_W-1:0] wrMask,
  input  logic [ADDR_W-1:0] wrBase,
  input  logic              wrSupV,
  input  logic              wrUserV,
  input  logic [PROT_W-1:0] wrProt,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqData,
  input  logic              reqUser,
  output logic              rspValid,
  output logic              rspHit,
  output logic [ADDR_W-1:0] rspPhys,
  output logic              rspRead,
  output logic              rspWrite,
  output logic              rspExec,
  output logic [TAG_W-1:0]  rspTag
);
  strobe_t strobe;

  blkmap_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSide(wrSide), .wrIdx(wrIdx),
    .reqValid(reqValid), .strobe(strobe), .rspValid(rspValid)
  );

  blkmap_dp i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrPattern(wrPattern), .wrMask(wrMask), .wrBase(wrBase),
    .wrSupV(wrSupV), .wrUserV(wrUserV), .wrProt(wrProt),
    .reqAddr(reqAddr), .reqData(reqData), .reqUser(reqUser),
    .rspHit(rspHit), .rspPhys(rspPhys), .rspRead(rspRead),
    .rspWrite(rspWrite), .rspExec(rspExec), .rspTag(rspTag)
  );

  // R9
  hold_between_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> ($stable(rspHit) && $stable(rspPhys) && $stable(rspTag)));
endmodule

// File: tb/test_blkmap_xlate.sv
`timescale 1ns/1ps
module test_blkmap_xlate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, wrSide = 1'b0;
  logic [2:0]  wrIdx = '0;
  logic [31:0] wrPattern = '0, wrMask = '0, wrBase = '0;
  logic        wrSupV = 1'b0, wrUserV = 1'b0;
  logic [1:0]  wrProt = '0;
  logic        reqValid = 1'b0, reqData = 1'b0, reqUser = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        rspValid, rspHit, rspRead, rspWrite, rspExec;
  logic [31:0] rspPhys;
  logic [20:0] rspTag;

  int compared = 0;
  int mismatched = 0;

  logic [31:0] mPat  [2][8];
  logic [31:0] mMask [2][8];
  logic [31:0] mBase [2][8];
  logic        mSup  [2][8];
  logic        mUser [2][8];
  logic [1:0]  mProt [2][8];

  always #2.5 clk = ~clk;

  blkmap_xlate i_blkmap_xlate (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSide(wrSide), .wrIdx(wrIdx),
    .wrPattern(wrPattern), .wrMask(wrMask), .wrBase(wrBase),
    .wrSupV(wrSupV), .wrUserV(wrUserV), .wrProt(wrProt),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqData(reqData), .reqUser(reqUser),
    .rspValid(rspValid), .rspHit(rspHit), .rspPhys(rspPhys), .rspRead(rspRead),
    .rspWrite(rspWrite), .rspExec(rspExec), .rspTag(rspTag)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #(5.0 * 150000);
    mismatched++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    summary();
    $finish;
  end

  function automatic void model(input logic [31:0] a, input logic d, input logic u,
                                output logic hit, output logic [31:0] ph,
                                output logic [20:0] tg);
    int s = d ? 1 : 0;
    hit = 1'b0; ph = '0; tg = '0;
    for (int i = 0; i < 8; i++) begin
      if (!hit && (u ? mUser[s][i] : mSup[s][i]) && ((a & mMask[s][i]) == mPat[s][i])
          && mProt[s][i] >= 2'd2) begin
        hit = 1'b1;
        ph  = mBase[s][i] | (a & ~mMask[s][i]);
        tg  = {1'b1, a[31:12]};
      end
    end
  endfunction

  function automatic void modelClear();
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 8; i++) begin
        mPat[s][i] = '0; mMask[s][i] = '0; mBase[s][i] = '0;
        mSup[s][i] = 1'b0; mUser[s][i] = 1'b0; mProt[s][i] = '0;
      end
  endfunction

  task automatic setWrite(input logic side, input logic [2:0] idx, input logic [31:0] pat,
                          input logic [31:0] msk, input logic [31:0] bas,
                          input logic sv, input logic uv, input logic [1:0] pr);
    wrEn = 1'b1; wrSide = side; wrIdx = idx; wrPattern = pat; wrMask = msk;
    wrBase = bas; wrSupV = sv; wrUserV = uv; wrProt = pr;
  endtask

  task automatic commitModel(input logic side, input logic [2:0] idx, input logic [31:0] pat,
                             input logic [31:0] msk, input logic [31:0] bas,
                             input logic sv, input logic uv, input logic [1:0] pr);
    int s = side ? 1 : 0;
    mPat[s][idx] = pat; mMask[s][idx] = msk; mBase[s][idx] = bas;
    mSup[s][idx] = sv; mUser[s][idx] = uv; mProt[s][idx] = pr;
  endtask

  // R10: one whole entry loaded per write
  task automatic writeEntry(input logic side, input logic [2:0] idx, input logic [31:0] pat,
                            input logic [31:0] msk, input logic [31:0] bas,
                            input logic sv, input logic uv, input logic [1:0] pr);
    setWrite(side, idx, pat, msk, bas, sv, uv, pr);
    @(negedge clk);
    wrEn = 1'b0;
    commitModel(side, idx, pat, msk, bas, sv, uv, pr);
  endtask

  task automatic compareRsp(input string req, input logic eHit, input logic [31:0] ePh,
                            input logic [20:0] eTg);
    logic ok;
    ok = rspValid === 1'b1 && rspHit === eHit && rspPhys === ePh && rspTag === eTg
         && rspRead === eHit && rspWrite === eHit && rspExec === eHit;
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual v=%b hit=%b phys=%h r/w/x=%b%b%b tag=%h expected v=1 hit=%b phys=%h r/w/x=%b%b%b tag=%h",
               req, rspValid, rspHit, rspPhys, rspRead, rspWrite, rspExec, rspTag,
               eHit, ePh, eHit, eHit, eHit, eTg);
    end
  endtask

  task automatic lookup(input string req, input logic [31:0] a, input logic d, input logic u);
    logic eHit; logic [31:0] ePh; logic [20:0] eTg;
    model(a, d, u, eHit, ePh, eTg);
    reqValid = 1'b1; reqAddr = a; reqData = d; reqUser = u;
    @(negedge clk);
    reqValid = 1'b0;
    compareRsp(req, eHit, ePh, eTg);
  endtask

  // R9: no request -> no valid, held outputs
  task automatic checkIdleHold(input string req);
    logic pHit; logic [31:0] pPh; logic [20:0] pTg;
    pHit = rspHit; pPh = rspPhys; pTg = rspTag;
    reqAddr = $urandom;
    @(negedge clk);
    compared++;
    if (rspValid !== 1'b0 || rspHit !== pHit || rspPhys !== pPh || rspTag !== pTg) begin
      mismatched++;
      $display("FAIL %s: actual v=%b hit=%b phys=%h tag=%h expected v=0 hit=%b phys=%h tag=%h",
               req, rspValid, rspHit, rspPhys, rspTag, pHit, pPh, pTg);
    end
  endtask

  function automatic logic [31:0] randMask();
    int k = 12 + int'($urandom % 17);
    return ~((32'd1 << k) - 32'd1);
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    modelClear();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state, all lookups miss with zero outputs
    compared++;
    if (rspValid !== 1'b0 || rspHit !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 reset idle: actual v=%b hit=%b expected v=0 hit=0", rspValid, rspHit);
    end
    lookup("R1 miss data super", 32'h8123_4567, 1'b1, 1'b0);
    lookup("R1 miss inst user",  32'h0000_0000, 1'b0, 1'b1);

    // R4 R5 R8: supervisor-only data entry
    writeEntry(1'b1, 3'd3, 32'h8000_0000, 32'hF000_0000, 32'h1000_0000, 1'b1, 1'b0, 2'd2);
    lookup("R4 R5 R8 data hit", 32'h8123_4567, 1'b1, 1'b0);
    lookup("R4 outside pattern miss", 32'h9123_4567, 1'b1, 1'b0);
    // R3: user mode does not see supervisor-only entry
    lookup("R3 user miss", 32'h8123_4567, 1'b1, 1'b1);
    // R2: instruction side does not see data table
    lookup("R2 inst side miss", 32'h8123_4567, 1'b0, 1'b0);
    checkIdleHold("R9 idle hold");

    // R7: overlapping entry at higher index, valid in both modes
    writeEntry(1'b1, 3'd5, 32'h8000_0000, 32'hFFF0_0000, 32'h2000_0000, 1'b1, 1'b1, 2'd3);
    lookup("R7 lower index wins", 32'h8000_1234, 1'b1, 1'b0);
    lookup("R3 R7 user falls to later entry", 32'h8000_1234, 1'b1, 1'b1);

    // R6: lower-index entries with protection 1 and 0 are skipped
    writeEntry(1'b1, 3'd1, 32'h8000_0000, 32'hF000_0000, 32'h3000_0000, 1'b1, 1'b0, 2'd1);
    writeEntry(1'b1, 3'd0, 32'h8000_0000, 32'hFF00_0000, 32'h5000_0000, 1'b1, 1'b1, 2'd0);
    lookup("R6 read-only skipped", 32'h8000_ABCD, 1'b1, 1'b0);
    lookup("R6 no-access skipped", 32'h8000_ABCD, 1'b1, 1'b1);

    // R2: instruction table entry with the same region but different base
    writeEntry(1'b0, 3'd3, 32'h8000_0000, 32'hF000_0000, 32'h7000_0000, 1'b1, 1'b1, 2'd2);
    lookup("R2 inst side own table", 32'h8765_4321, 1'b0, 1'b0);
    lookup("R2 data side unaffected", 32'h8765_4321, 1'b1, 1'b0);

    // R9: write and lookup in the same cycle, old contents used
    setWrite(1'b1, 3'd3, 32'h8000_0000, 32'hF000_0000, 32'h4000_0000, 1'b1, 1'b0, 2'd2);
    lookup("R9 same-cycle write sees old", 32'h8000_0040, 1'b1, 1'b0);
    wrEn = 1'b0;
    commitModel(1'b1, 3'd3, 32'h8000_0000, 32'hF000_0000, 32'h4000_0000, 1'b1, 1'b0, 2'd2);
    lookup("R9 R10 next lookup sees new", 32'h8000_0040, 1'b1, 1'b0);
    lookup("R10 other entry untouched", 32'h8000_0040, 1'b1, 1'b1);

    // Random phase
    for (int it = 0; it < 600; it++) begin
      int sel = int'($urandom % 4);
      if (sel == 0) begin
        logic [31:0] m = randMask();
        writeEntry(1'($urandom), 3'($urandom), $urandom & m, m, $urandom & m,
                   1'($urandom), 1'($urandom), 2'($urandom));
      end else begin
        logic d = 1'($urandom);
        int s = d ? 1 : 0;
        logic [2:0] e = 3'($urandom);
        logic [31:0] a = (sel == 3) ? $urandom
                       : (mPat[s][e] | ($urandom & ~mMask[s][e]));
        lookup("R3 R4 R5 R6 R7 random", a, d, 1'($urandom));
        if (it % 50 == 0) checkIdleHold("R9 random idle hold");
      end
    end

    summary();
    $finish;
  end
endmodule